// File: doc/BRIEF.md
# UART Transmit Framer with Multidrop Wake-up

This block turns a parallel byte into an asynchronous serial character. A byte written into a one-entry holding register moves into a frame shifter as soon as the shifter is idle. The shifter then drives the line with a low start bit, 5 to 8 data bits least significant first, an optional ninth-position bit, and one high stop bit. Each bit lasts a fixed number of bit-rate ticks, 16 by default. The tick comes from an external baud generator.

A 2-bit mode input decides what goes in the position after the data bits. It can carry a computed even or odd parity bit, a forced constant level, nothing at all, or an address/data marker for multidrop wake-up links. In the wake-up case, a qualifier presented with each byte tags it as an address or a data byte. All mode inputs are sampled when a byte moves from the holding register into the shifter, so they may change while a character is on the line. The empty flag tells the host when both stages are free.

Top module: `uart_tx_framer`

## Requirements
- R1: While reset is asserted and right after it is released, `txd_o` is 1 and `tx_empty_o` is 1.
- R2: A character is sent as a start bit (0), then N data bits LSB first, where `char_len_i` codes 00/01/10/11 give N = 5/6/7/8, then the optional extra bit, then one stop bit (1). Each bit lasts OVERSAMPLE (16) ticks of `tick_i`, and the line changes only on a tick, except at the start of a frame.
- R3: With `par_mode_i` = 00 the extra bit is parity over the N data bits only. `par_type_i` = 0 gives even parity and 1 gives odd parity.
- R4: With `par_mode_i` = 01 the extra bit equals `par_type_i`.
- R5: With `par_mode_i` = 10 no extra bit is sent, so the stop bit follows the last data bit directly. `par_type_i` has no effect on the frame.
- R6: With `par_mode_i` = 11 (wake-up) the extra bit equals `par_type_i` when the byte was loaded with `addr_i` = 1, and its inverse when it was loaded with `addr_i` = 0.
- R7: `tx_empty_o` falls in the cycle after a load into an empty holding register. It stays low until the stop bit of the last queued character has finished.
- R8: A load while the holding register is full is ignored. A byte in the holding register is sent immediately after the character in progress.
- R9: Mode, type and length inputs are captured when a byte enters the shifter. Changes to them during a frame do not alter that frame.
- R10: The line is high whenever no character is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bit-rate tick, one cycle wide |
| load_i | input | 1 | Write strobe for the holding register |
| data_i | input | 8 | Byte to send |
| addr_i | input | 1 | Wake-up qualifier: 1 = address byte, 0 = data byte |
| par_mode_i | input | 2 | 00 computed, 01 forced, 10 none, 11 wake-up |
| par_type_i | input | 1 | Parity sense, forced level or address polarity |
| char_len_i | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| txd_o | output | 1 | Serial line, idles high |
| tx_empty_o | output | 1 | High when holding register and shifter are both empty |

## Verification
On every cycle, the assertions check the idle-high line, the low start bit at the beginning of each frame, and that the line holds still between ticks. They also check the empty flag's reaction to loads and that a blocked load leaves the held byte untouched. The content of a frame can only be shown by the bench's scenarios. That covers data order, character length, the parity, forced and wake-up bit values, the missing bit in no-parity mode, and capture of the mode at transfer. The bench decodes the line at mid-bit over every length, mode and type combination, at two tick rates.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    PAR_CALC  = 2'b00,
    PAR_FORCE = 2'b01,
    PAR_NONE  = 2'b10,
    PAR_WAKE  = 2'b11
  } par_mode_e;

  localparam int unsigned MIN_DATA_BITS = 5;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              addr_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      addr_o  <= 1'b0;
    end else if (!valid_o) begin
      if (load_i) begin
        valid_o <= 1'b1;
        data_o  <= data_i;
        addr_o  <= addr_i;
      end
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned FRAME_W = DATA_W + 3,
  parameter int unsigned NB_W    = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic               addr_i,
  input  par_mode_e          mode_i,
  input  logic               type_i,
  input  logic [1:0]         len_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [NB_W-1:0]    nbits_o
);
  logic [DATA_W-1:0] mask;
  logic [NB_W-1:0]   ndata;
  logic              extra_bit;
  logic              has_extra;

  assign ndata = NB_W'(MIN_DATA_BITS) + NB_W'(len_i);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (NB_W'(i) < ndata);
  end

  always_comb begin
    unique case (mode_i)
      PAR_CALC:  extra_bit = (^(data_i & mask)) ^ type_i;
      PAR_FORCE: extra_bit = type_i;
      PAR_WAKE:  extra_bit = addr_i ? type_i : ~type_i;
      default:   extra_bit = 1'b1;
    endcase
    has_extra = (mode_i != PAR_NONE);
  end

  // bit 0 is the start bit; unused upper positions stay high (stop/idle)
  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (mask[i]) frame_o[i+1] = data_i[i];
    end
    if (has_extra) frame_o[ndata + NB_W'(1)] = extra_bit;
    nbits_o = ndata + NB_W'(2) + NB_W'(has_extra);
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int unsigned FRAME_W    = 11,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned NB_W       = $clog2(FRAME_W + 1),
  parameter int unsigned CNT_W      = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [NB_W-1:0]    nbits_i,
  output logic               busy_o,
  output logic               txd_o
);
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   tcnt;
  logic [NB_W-1:0]    left;
  logic               bit_end;

  assign bit_end = tick_i && (tcnt == CNT_W'(OVERSAMPLE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg   <= '1;
      busy_o <= 1'b0;
      tcnt   <= '0;
      left   <= '0;
    end else if (start_i && !busy_o) begin
      sreg   <= frame_i;
      busy_o <= 1'b1;
      tcnt   <= '0;
      left   <= nbits_i;
    end else if (busy_o && tick_i) begin
      if (bit_end) begin
        tcnt <= '0;
        sreg <= {1'b1, sreg[FRAME_W-1:1]};
        left <= left - NB_W'(1);
        if (left == NB_W'(1)) busy_o <= 1'b0;
      end else begin
        tcnt <= tcnt + CNT_W'(1);
      end
    end
  end

  assign txd_o = busy_o ? sreg[0] : 1'b1;
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              addr_i,
  input  logic [1:0]        par_mode_i,
  input  logic              par_type_i,
  input  logic [1:0]        char_len_i,
  output logic              txd_o,
  output logic              tx_empty_o
);
  localparam int unsigned FRAME_W = DATA_W + 3;
  localparam int unsigned NB_W    = $clog2(FRAME_W + 1);

  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              hold_addr;
  logic              busy;
  logic              take;
  logic [FRAME_W-1:0] frame;
  logic [NB_W-1:0]    nbits;

  assign take = hold_valid && !busy;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .data_i  (data_i),
    .addr_i  (addr_i),
    .take_i  (take),
    .valid_o (hold_valid),
    .data_o  (hold_data),
    .addr_o  (hold_addr)
  );

  uart_tx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .NB_W(NB_W)) u_frame (
    .data_i  (hold_data),
    .addr_i  (hold_addr),
    .mode_i  (par_mode_e'(par_mode_i)),
    .type_i  (par_type_i),
    .len_i   (char_len_i),
    .frame_o (frame),
    .nbits_o (nbits)
  );

  uart_tx_shift #(.FRAME_W(FRAME_W), .OVERSAMPLE(OVERSAMPLE), .NB_W(NB_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .start_i (take),
    .frame_i (frame),
    .nbits_i (nbits),
    .busy_o  (busy),
    .txd_o   (txd_o)
  );

  assign tx_empty_o = !hold_valid && !busy;
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              load_i,
  input logic              txd_o,
  input logic              tx_empty_o,
  input logic              busy,
  input logic              hold_valid,
  input logic [DATA_W-1:0] hold_data
);
  assert_idle_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> txd_o);

  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !txd_o);

  assert_bit_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !tick_i) |=> $stable(txd_o));

  assert_empty_falls_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && tx_empty_o) |=> !tx_empty_o);

  assert_empty_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !load_i) |=> tx_empty_o);

  assert_full_load_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_valid && busy && load_i) |=> (hold_valid && $stable(hold_data)));
endmodule

bind uart_tx_framer uart_tx_framer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .load_i     (load_i),
  .txd_o      (txd_o),
  .tx_empty_o (tx_empty_o),
  .busy       (busy),
  .hold_valid (hold_valid),
  .hold_data  (hold_data)
);

// File: tb/uart_tx_framer_tb_top.sv
module uart_tx_framer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       load = 1'b0;
  logic [7:0] data = '0;
  logic       addr = 1'b0;
  logic [1:0] pmode = 2'b00;
  logic       ptype = 1'b0;
  logic [1:0] clen = 2'b11;
  logic       txd, empty;

  int checks = 0;
  int errors = 0;
  int tdiv = 1;
  int tcount = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_tx_framer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .load_i(load), .data_i(data),
    .addr_i(addr), .par_mode_i(pmode), .par_type_i(ptype), .char_len_i(clen),
    .txd_o(txd), .tx_empty_o(empty)
  );

  always @(negedge clk) begin
    if (tcount >= tdiv - 1) begin tick <= 1'b1; tcount <= 0; end
    else begin tick <= 1'b0; tcount <= tcount + 1; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    finish_sim();
  end

  // expected frame from the requirements: bit0 start, data LSB first, extra, stop
  function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic a,
      input logic [1:0] m, input logic t, input logic [1:0] l, output int nb);
    logic [10:0] f;
    int n;
    logic x;
    int par;
    n = 5 + l;
    f = '1;
    f[0] = 1'b0;
    par = 0;
    for (int i = 0; i < n; i++) begin
      f[i+1] = d[i];
      par += d[i];
    end
    case (m)
      2'b00: x = (par % 2 == 1) ^ t;
      2'b01: x = t;
      2'b11: x = a ? t : ~t;
      default: x = 1'b1;
    endcase
    if (m != 2'b10) begin
      f[n+1] = x;
      nb = n + 3;
    end else begin
      nb = n + 2;
    end
    return f;
  endfunction

  task automatic send(input logic [7:0] d, input logic a);
    @(negedge clk);
    data = d; addr = a; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic rx_frame(input int nb, output logic [10:0] got);
    int w;
    got = '1;
    w = 0;
    while (txd === 1'b1 && w < 4000) begin @(negedge clk); w++; end
    repeat (8 * tdiv) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      got[i] = txd;
      if (i < nb - 1) repeat (16 * tdiv) @(negedge clk);
    end
  endtask

  task automatic wait_empty();
    int w;
    w = 0;
    while (empty !== 1'b1 && w < 4000) begin @(negedge clk); w++; end
  endtask

  initial begin
    logic [10:0] got, exp;
    int nb;
    string rq;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R1", "txd in reset", txd, 1);
    chk(empty === 1'b1, "R1", "empty in reset", empty, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd === 1'b1, "R1", "txd after reset", txd, 1);
    chk(empty === 1'b1, "R1", "empty after reset", empty, 1);

    // R2..R6 sweep over length, mode, type, data and tick rate
    for (int l = 0; l < 4; l++) begin
      for (int m = 0; m < 4; m++) begin
        for (int t = 0; t < 2; t++) begin
          for (int k = 0; k < 4; k++) begin
            logic [7:0] d;
            d = 8'(k * 8'h5B + l * 8'h11 + m * 7 + t * 8'h80);
            tdiv = (k == 3) ? 3 : 1;
            pmode = 2'(m); ptype = 1'(t); clen = 2'(l);
            case (m)
              0: rq = "R3";
              1: rq = "R4";
              2: rq = "R5";
              default: rq = "R6";
            endcase
            exp = exp_frame(d, 1'(k), 2'(m), 1'(t), 2'(l), nb);
            send(d, 1'(k));
            chk(empty === 1'b0, "R7", "empty after load", empty, 0);
            rx_frame(nb, got);
            chk(got === exp, rq, "R2 frame bits", 32'(got), 32'(exp));
            wait_empty();
            @(negedge clk);
            chk(txd === 1'b1 && empty === 1'b1, "R10", "idle line/empty",
                {txd, empty}, 2'b11);
          end
        end
      end
    end

    // R8: queued byte follows, load while full is ignored
    tdiv = 1;
    pmode = 2'b00; ptype = 1'b0; clen = 2'b11;
    begin
      logic [10:0] ea, eb;
      int na, nbb;
      ea = exp_frame(8'h96, 1'b0, 2'b00, 1'b0, 2'b11, na);
      eb = exp_frame(8'h4D, 1'b0, 2'b00, 1'b0, 2'b11, nbb);
      send(8'h96, 1'b0);
      repeat (3) @(negedge clk);
      data = 8'h4D; load = 1'b1;
      @(negedge clk);
      data = 8'hE1;
      @(negedge clk);
      load = 1'b0;
      rx_frame(na, got);
      chk(got === ea, "R8", "first frame", 32'(got), 32'(ea));
      chk(empty === 1'b0, "R7", "empty while byte queued", empty, 0);
      rx_frame(nbb, got);
      chk(got === eb, "R8", "queued frame", 32'(got), 32'(eb));
      wait_empty();
      begin
        bit low_seen;
        low_seen = 0;
        for (int i = 0; i < 48; i++) begin
          @(negedge clk);
          if (txd !== 1'b1) low_seen = 1;
        end
        chk(!low_seen, "R8", "ignored load produced a frame", low_seen, 0);
      end
    end

    // R9: mode change during a frame has no effect
    begin
      logic [10:0] e9;
      int n9;
      pmode = 2'b00; ptype = 1'b1; clen = 2'b10;
      e9 = exp_frame(8'h35, 1'b0, 2'b00, 1'b1, 2'b10, n9);
      send(8'h35, 1'b0);
      fork
        rx_frame(n9, got);
        begin
          repeat (20) @(negedge clk);
          pmode = 2'b10; ptype = 1'b0; clen = 2'b00;
        end
      join
      chk(got === e9, "R9", "frame after mid-frame mode change", 32'(got), 32'(e9));
      wait_empty();
    end

    finish_sim();
  end
endmodule